// File: doc/BRIEF.md
# Paged I2C Register Target

This block is an I2C target that gives a host access to a banked file of byte-wide registers. The host selects a register with an 8-bit register address. Each address holds one byte, and wider fields are built from neighbouring addresses. A page register selects which bank the other addresses reach. The page register answers at the same address in every bank, so the host can always move between banks.

The target answers only to device address 0x32. On the wire this is the byte 0x64 for a write and 0x65 for a read. A write transfers one data byte to the latched register address. A read sets the register address in a write phase, then issues a repeated start and a read-direction address byte, and the target returns one byte. The last register address stays latched, so a read can also start directly with the read-direction address.

Bank 0 holds a fixed identity value at its first two addresses. Bank 0 also holds a control byte in which one bit mirrors an external status input and cannot be written. SCL and SDA are brought into the system clock domain through synchronisers and a glitch filter. SDA is driven open-drain: the target only ever pulls the line low.

Top module: `paged_i2c_target`

## Requirements
- R1: After reset the target does not pull SDA low, `pageSel` is 0, and every stored byte in `regImage` is 0.
- R2: The target acknowledges an address byte whose upper seven bits are 0x32 (bit 0 is the direction: 0 means write, 1 means read). In a write it also acknowledges the register-address byte and the data byte.
- R3: For an address byte with any other upper seven bits, the target gives no acknowledge and never pulls SDA low until the next start or stop. No register changes during that transaction.
- R4: A write stores its data byte at the latched address in the current page. That byte appears in `regImage` at bit offset (page*DEPTH + address)*8.
- R5: A read returns the addressed byte most significant bit first. SDA is changed only after a falling SCL, a start or a stop. The target then releases SDA for the host's NACK.
- R6: On page 0, address 0x00 reads 0x06 and address 0x01 reads 0x01, forming the identity 0x0601 with the high byte at the lower address. Writes to these two addresses are ignored.
- R7: On page 0, bit 5 of address 0x05 always reads the `statusIn` input. A write to that bit is ignored and the bit is stored as 0, while the other seven bits are writable.
- R8: Address 0xF0 reads and writes the page number from any page. A written value of NUM_PAGES or more is ignored. The same address on different pages reaches separate storage, and the identity bytes exist only on page 0. `pageSel` changes only as the result of a completed data write.
- R9: The register address latched by a write phase persists. A read that starts directly with 0x65 returns the byte at that address in the current page.
- R10: A start or stop in the middle of a byte returns the target to idle without a write, and releases SDA. A new transaction that follows is served normally.
- R11: An address at or above DEPTH, other than 0xF0, reads 0x00, and a write to it is ignored. Address DEPTH-1 is an ordinary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | I2C clock line level |
| sdaIn | input | 1 | I2C data line level |
| statusIn | input | 1 | Status flag shown in the read-only bit of the control byte |
| sdaDriveLow | output | 1 | When 1, the SDA pad is pulled low (open-drain enable) |
| pageSel | output | PAGE_W | Currently selected register page |
| regImage | output | NUM_PAGES*DEPTH*8 | Flat image of all stored bytes, page-major |

## Verification
The bench builds the block with its defaults:
- two pages of 16 bytes;
- a three-cycle glitch filter;
- control byte at 0x05 with its read-only bit at position 5.

With two pages, page values such as 7 are out of range, so the bench can check that the page register ignores them. The bench can also show that the same address on the two pages keeps separate contents. A depth of 16 puts address 0x0F on the last real register and 0x20 in the unmapped range, so both sides of that boundary are checked.

The SCL half period is long compared with the filter delay. This lets the bench place a start or stop between arbitrary bits, and observe at SDA that an unaddressed transaction never draws a low from the target.

// File: rtl/pgi2c_pkg.sv
package pgi2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_DEVACK,
    ST_REGADR,
    ST_REGACK,
    ST_WRDATA,
    ST_WRACK,
    ST_TXDATA,
    ST_HOSTACK,
    ST_IGNORE
  } busState_e;

  typedef struct packed {
    logic       addrLoad;
    logic       dataWrite;
    logic [7:0] busByte;
  } regStrobe_t;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1;

  logic [1:0] rawIn;
  logic [1:0] filt;
  logic [1:0] filtPrev;

  assign rawIn = {sclRaw, sdaRaw};

  // index 1 carries SCL, index 0 carries SDA
  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [1:0]       syncQ;
    logic [CNT_W-1:0] stableCnt;
    logic             level;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ     <= 2'b11;
        stableCnt <= '0;
        level     <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[i]};
        if (syncQ[1] == level) begin
          stableCnt <= '0;
        end else if (stableCnt == CNT_W'(FILT_LEN - 1)) begin
          level     <= syncQ[1];
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end
    end

    assign filt[i] = level;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) filtPrev <= 2'b11;
    else       filtPrev <= filt;
  end

  assign sdaLevel  = filt[0];
  assign sclRise   = filt[1] & ~filtPrev[1];
  assign sclFall   = ~filt[1] & filtPrev[1];
  assign startSeen = filt[1] & filtPrev[1] & filtPrev[0] & ~filt[0];
  assign stopSeen  = filt[1] & filtPrev[1] & ~filtPrev[0] & filt[0];
endmodule

// File: rtl/i2c_bus_ctrl.sv
module i2c_bus_ctrl
  import pgi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaLevel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic [7:0] rdByte,
  output regStrobe_t strobe,
  output logic       sdaDriveLow
);
  busState_e  state;
  logic [7:0] shiftQ;
  logic [3:0] bitCnt;
  logic       isRead;
  logic       byteDone;
  logic       rxState;

  assign byteDone = sclFall && (bitCnt == 4'd8);
  assign rxState  = (state == ST_DEVADR) || (state == ST_REGADR) || (state == ST_WRDATA);

  always_comb begin
    strobe.busByte   = shiftQ;
    strobe.addrLoad  = (state == ST_REGADR) && byteDone;
    strobe.dataWrite = (state == ST_WRDATA) && byteDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      shiftQ      <= '0;
      bitCnt      <= '0;
      isRead      <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (startSeen) begin
      state       <= ST_DEVADR;
      bitCnt      <= '0;
      sdaDriveLow <= 1'b0;
    end else if (stopSeen) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      sdaDriveLow <= 1'b0;
    end else if (rxState) begin
      if (sclRise && (bitCnt < 4'd8)) begin
        shiftQ <= {shiftQ[6:0], sdaLevel};
        bitCnt <= bitCnt + 4'd1;
      end else if (byteDone) begin
        bitCnt <= '0;
        case (state)
          ST_DEVADR: begin
            if (shiftQ[7:1] == DEV_ADDR) begin
              sdaDriveLow <= 1'b1;
              isRead      <= shiftQ[0];
              state       <= ST_DEVACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_REGADR: begin
            sdaDriveLow <= 1'b1;
            state       <= ST_REGACK;
          end
          default: begin
            sdaDriveLow <= 1'b1;
            state       <= ST_WRACK;
          end
        endcase
      end
    end else if (sclFall) begin
      case (state)
        ST_DEVACK: begin
          if (isRead) begin
            shiftQ      <= rdByte;
            sdaDriveLow <= ~rdByte[7];
            bitCnt      <= 4'd1;
            state       <= ST_TXDATA;
          end else begin
            sdaDriveLow <= 1'b0;
            state       <= ST_REGADR;
          end
        end
        ST_REGACK: begin
          sdaDriveLow <= 1'b0;
          state       <= ST_WRDATA;
        end
        ST_WRACK: begin
          sdaDriveLow <= 1'b0;
          state       <= ST_IGNORE;
        end
        ST_TXDATA: begin
          if (bitCnt == 4'd8) begin
            sdaDriveLow <= 1'b0;
            state       <= ST_HOSTACK;
          end else begin
            sdaDriveLow <= ~shiftQ[6];
            shiftQ      <= {shiftQ[6:0], 1'b0};
            bitCnt      <= bitCnt + 4'd1;
          end
        end
        ST_HOSTACK: state <= ST_IGNORE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pg_reg_dp.sv
module pg_reg_dp
  import pgi2c_pkg::*;
#(
  parameter int          NUM_PAGES = 2,
  parameter int          DEPTH     = 16,
  parameter logic [7:0]  PAGE_ADDR = 8'hF0,
  parameter logic [15:0] ID_VALUE  = 16'h0601,
  parameter logic [7:0]  CTRL_ADDR = 8'h05,
  parameter int          LOCK_BIT  = 5,
  parameter int          PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  regStrobe_t                   strobe,
  input  logic                         statusIn,
  output logic [7:0]                   rdByte,
  output logic [PAGE_W-1:0]            pageSel,
  output logic [NUM_PAGES*DEPTH*8-1:0] regImage
);
  localparam int         IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [8:0] DEPTH_LIM = 9'(DEPTH);
  localparam logic [8:0] PAGE_LIM  = 9'(NUM_PAGES);
  localparam logic [7:0] LOCK_MASK = 8'(1) << LOCK_BIT;

  logic [7:0]       mem [NUM_PAGES][DEPTH];
  logic [7:0]       curAddr;
  logic [IDX_W-1:0] curIdx;
  logic             onPage0;
  logic             hitPage;
  logic             hitId;
  logic             hitCtrl;
  logic             inRange;

  assign curIdx  = curAddr[IDX_W-1:0];
  assign onPage0 = (pageSel == '0);
  assign hitPage = (curAddr == PAGE_ADDR);
  assign hitId   = onPage0 && (curAddr[7:1] == 7'd0);
  assign hitCtrl = onPage0 && (curAddr == CTRL_ADDR);
  assign inRange = ({1'b0, curAddr} < DEPTH_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      pageSel <= '0;
      for (int p = 0; p < NUM_PAGES; p++)
        for (int a = 0; a < DEPTH; a++)
          mem[p][a] <= '0;
    end else begin
      if (strobe.addrLoad) curAddr <= strobe.busByte;
      if (strobe.dataWrite) begin
        if (hitPage) begin
          if ({1'b0, strobe.busByte} < PAGE_LIM) pageSel <= strobe.busByte[PAGE_W-1:0];
        end else if (!hitId && inRange) begin
          mem[pageSel][curIdx] <= hitCtrl ? (strobe.busByte & ~LOCK_MASK) : strobe.busByte;
        end
      end
    end
  end

  always_comb begin
    rdByte = 8'h00;
    if (hitPage) begin
      rdByte = 8'(pageSel);
    end else if (hitId) begin
      rdByte = curAddr[0] ? ID_VALUE[7:0] : ID_VALUE[15:8];
    end else if (inRange) begin
      rdByte = mem[pageSel][curIdx];
      if (hitCtrl) rdByte[LOCK_BIT] = statusIn;
    end
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    for (genvar a = 0; a < DEPTH; a++) begin : g_byte
      assign regImage[(p*DEPTH + a)*8 +: 8] = mem[p][a];
    end
  end
endmodule

// File: rtl/paged_i2c_target.sv
module paged_i2c_target
  import pgi2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h32,
  parameter int          NUM_PAGES = 2,
  parameter int          DEPTH     = 16,
  parameter logic [7:0]  PAGE_ADDR = 8'hF0,
  parameter logic [15:0] ID_VALUE  = 16'h0601,
  parameter logic [7:0]  CTRL_ADDR = 8'h05,
  parameter int          LOCK_BIT  = 5,
  parameter int          FILT_LEN  = 3,
  localparam int         PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int         IMG_W     = NUM_PAGES * DEPTH * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              statusIn,
  output logic              sdaDriveLow,
  output logic [PAGE_W-1:0] pageSel,
  output logic [IMG_W-1:0]  regImage
);
  logic       sdaLevel;
  logic       sclRise;
  logic       sclFall;
  logic       startSeen;
  logic       stopSeen;
  logic [7:0] rdByte;
  regStrobe_t strobe;

  i2c_line_cond #(.FILT_LEN(FILT_LEN)) line_i (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .sdaLevel(sdaLevel), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2c_bus_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .rdByte(rdByte), .strobe(strobe), .sdaDriveLow(sdaDriveLow)
  );

  pg_reg_dp #(
    .NUM_PAGES(NUM_PAGES), .DEPTH(DEPTH), .PAGE_ADDR(PAGE_ADDR),
    .ID_VALUE(ID_VALUE), .CTRL_ADDR(CTRL_ADDR), .LOCK_BIT(LOCK_BIT),
    .PAGE_W(PAGE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusIn(statusIn),
    .rdByte(rdByte), .pageSel(pageSel), .regImage(regImage)
  );
endmodule

// File: rtl/paged_i2c_chk.sv
module paged_i2c_chk
  import pgi2c_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  parameter int PAGE_W    = 1,
  parameter int IMG_W     = 256,
  parameter int LOCK_POS  = 45
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaDriveLow,
  input logic [PAGE_W-1:0] pageSel,
  input logic [IMG_W-1:0]  regImage,
  input regStrobe_t        strobe,
  input logic              sclFall,
  input logic              startSeen,
  input logic              stopSeen
);
  // R8
  page_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(pageSel) < NUM_PAGES);

  // R8
  page_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pageSel) |-> $past(strobe.dataWrite));

  // R7
  lock_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    regImage[LOCK_POS] == 1'b0);

  // R5
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> $past(sclFall || startSeen || stopSeen));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaDriveLow);
endmodule

bind paged_i2c_target paged_i2c_chk #(
  .NUM_PAGES(NUM_PAGES),
  .PAGE_W(PAGE_W),
  .IMG_W(IMG_W),
  .LOCK_POS(int'(CTRL_ADDR) * 8 + LOCK_BIT)
) chk_i (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .pageSel(pageSel),
  .regImage(regImage), .strobe(strobe), .sclFall(sclFall),
  .startSeen(startSeen), .stopSeen(stopSeen)
);

// File: tb/paged_i2c_target_tb_top.sv
module paged_i2c_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 24;
  localparam int QTR        = 12;
  localparam int NPG        = 2;
  localparam int DEP        = 16;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           sclH = 1'b1;
  logic           sdaH = 1'b1;
  logic           statusIn = 1'b0;
  logic           sdaDriveLow;
  logic [0:0]     pageSel;
  logic [NPG*DEP*8-1:0] regImage;
  logic           sdaLine;
  int             nChecks = 0;
  int             nFail = 0;
  int             driveCnt = 0;

  typedef struct {
    string      tag;
    logic [7:0] val;
  } exp_t;
  exp_t       expQ[$];
  logic [7:0] obsByte;
  event       gotByte;

  assign sdaLine = sdaH & ~sdaDriveLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (sdaDriveLow) driveCnt <= driveCnt + 1;

  paged_i2c_target dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclH), .sdaIn(sdaLine),
    .statusIn(statusIn), .sdaDriveLow(sdaDriveLow),
    .pageSel(pageSel), .regImage(regImage)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare each byte the host receives against the queue
  always @(gotByte) begin
    exp_t e;
    if (expQ.size() == 0) begin
      check("READ-unexpected", 1, 0);
    end else begin
      e = expQ.pop_front();
      check(e.tag, obsByte, e.val);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaH = 1'b1; tick(QTR);
    sclH = 1'b1; tick(QTR);
    sdaH = 1'b0; tick(QTR);
    sclH = 1'b0;
  endtask

  task automatic busStop();
    tick(QTR); sdaH = 1'b0; tick(QTR);
    sclH = 1'b1; tick(QTR);
    sdaH = 1'b1; tick(QTR);
  endtask

  task automatic sendBit(input logic b);
    tick(QTR); sdaH = b; tick(QTR);
    sclH = 1'b1; tick(HALF);
    sclH = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    tick(QTR); sdaH = 1'b1; tick(QTR);
    sclH = 1'b1; tick(QTR);
    ack = (sdaLine == 1'b0);
    tick(QTR); sclH = 1'b0;
  endtask

  task automatic recvByte(output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      tick(QTR); sdaH = 1'b1; tick(QTR);
      sclH = 1'b1; tick(QTR);
      v = {v[6:0], sdaLine};
      tick(QTR); sclH = 1'b0;
    end
    sendBit(1'b1);
  endtask

  task automatic regWrite(input logic [7:0] addr, input logic [7:0] data);
    logic a1, a2, a3;
    busStart();
    sendByte(8'h64, a1);
    sendByte(addr, a2);
    sendByte(data, a3);
    busStop();
    check("R2 write acks", {a1, a2, a3}, 3'b111);
  endtask

  task automatic regRead(input string tag, input logic [7:0] addr, input logic [7:0] expVal);
    logic a1, a2, a3;
    logic [7:0] v;
    expQ.push_back('{tag, expVal});
    busStart();
    sendByte(8'h64, a1);
    sendByte(addr, a2);
    busStart();
    sendByte(8'h65, a3);
    recvByte(v);
    busStop();
    check("R2 read acks", {a1, a2, a3}, 3'b111);
    obsByte = v;
    -> gotByte;
    tick(2);
  endtask

  function automatic logic [7:0] imgByte(input int page, input int addr);
    return regImage[(page*DEP + addr)*8 +: 8];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    int d0;
    tick(5);
    rstN = 1'b1;
    tick(5);
    // R1 reset state
    check("R1 drive", sdaDriveLow, 0);
    check("R1 page", pageSel, 0);
    check("R1 image", (regImage == '0), 1);

    // R4 / R5 write then read, two data patterns
    regWrite(8'h03, 8'hA5);
    check("R4 image p0a3", imgByte(0, 3), 8'hA5);
    regRead("R5 read 0x03", 8'h03, 8'hA5);
    regWrite(8'h04, 8'h5A);
    check("R4 image p0a4", imgByte(0, 4), 8'h5A);
    regRead("R5 read 0x04", 8'h04, 8'h5A);

    // R3 foreign device addresses
    d0 = driveCnt;
    busStart();
    sendByte(8'h6A, ack);
    check("R3 nack 0x6A", ack, 0);
    sendByte(8'h03, ack);
    sendByte(8'hFF, ack);
    busStop();
    busStart();
    sendByte(8'h66, ack);
    check("R3 nack 0x66", ack, 0);
    busStop();
    check("R3 no drive", driveCnt - d0, 0);
    check("R3 no write", imgByte(0, 3), 8'hA5);

    // R6 identity
    regRead("R6 id hi", 8'h00, 8'h06);
    regRead("R6 id lo", 8'h01, 8'h01);
    regWrite(8'h00, 8'hFF);
    regRead("R6 id write ignored", 8'h00, 8'h06);

    // R7 read-only status bit
    statusIn = 1'b1;
    regWrite(8'h05, 8'h00);
    regRead("R7 status set", 8'h05, 8'h20);
    statusIn = 1'b0;
    regWrite(8'h05, 8'hFF);
    regRead("R7 status clear", 8'h05, 8'hDF);
    check("R7 stored bit", imgByte(0, 5), 8'hDF);

    // R8 paging
    regWrite(8'hF0, 8'h01);
    check("R8 pageSel", pageSel, 1);
    regRead("R8 page readback", 8'hF0, 8'h01);
    regWrite(8'h03, 8'h3C);
    regRead("R8 p1 a3", 8'h03, 8'h3C);
    regWrite(8'h00, 8'h77);
    regRead("R8 p1 a0 plain", 8'h00, 8'h77);
    regWrite(8'hF0, 8'h07);
    regRead("R8 bad page ignored", 8'hF0, 8'h01);
    regWrite(8'hF0, 8'h00);
    regRead("R8 p0 a3 kept", 8'h03, 8'hA5);
    check("R8 image p1a3", imgByte(1, 3), 8'h3C);

    // R9 address persistence
    busStart();
    sendByte(8'h64, ack);
    sendByte(8'h04, ack);
    busStop();
    expQ.push_back('{"R9 persisted addr", 8'h5A});
    busStart();
    sendByte(8'h65, ack);
    check("R9 ack", ack, 1);
    recvByte(v);
    busStop();
    obsByte = v; -> gotByte; tick(2);

    // R10 aborts
    busStart();
    for (int i = 0; i < 4; i++) sendBit(i[0]);
    busStop();
    regRead("R10 after stop abort", 8'h03, 8'hA5);
    busStart();
    sendByte(8'h64, ack);
    sendByte(8'h04, ack);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    busStop();
    check("R10 drive released", sdaDriveLow, 0);
    regRead("R10 no partial write", 8'h04, 8'h5A);
    busStart();
    sendByte(8'h64, ack);
    sendByte(8'h04, ack);
    sendBit(1'b0); sendBit(1'b1);
    busStart();
    sendByte(8'h64, ack);
    sendByte(8'h06, ack);
    sendByte(8'h11, ack);
    busStop();
    check("R10 restart write ack", ack, 1);
    regRead("R10 restart served", 8'h06, 8'h11);
    regRead("R10 aborted addr intact", 8'h04, 8'h5A);

    // R11 unmapped range and last real address
    regWrite(8'h20, 8'h99);
    regRead("R11 unmapped", 8'h20, 8'h00);
    regWrite(8'h0F, 8'h42);
    regRead("R11 last addr", 8'h0F, 8'h42);

    tick(10);
    check("R5 scoreboard drained", expQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule